// File: doc/BRIEF.md
# Dual-Port Bank Collision Arbiter

This block sits between two user command ports, A and B, and a memory command interface. On every clock each port offers a command set of four channel slots. Each slot has a valid flag, a write flag and an address. The three lowest address bits select one of eight banks. Slot n of port A is compared with slot n of port B, and with no other slot. When both slots are valid and the bank bits are equal, the two ports collide on that channel.

Any collision, on any channel, stalls the whole four-slot set of the losing port. That set is captured and issued again in the next clock, unchanged. The port's single ready output is low for exactly that replay clock, and a set offered while ready is low is dropped. Port A wins when neither port is replaying. A port that is replaying wins over fresh traffic. Two ports that keep hitting the same bank therefore take turns clock by clock.

Top module: `bank_coll_arb`

## Requirements
- R1: The bank of a slot is address bits [2:0]. A collision needs all three bits equal; higher address bits play no part.
- R2: Slot n of port A is compared only with slot n of port B. Equal banks on different slot indices never collide.
- R3: A slot whose valid flag is low never takes part in a collision.
- R4: When neither port is replaying and a collision occurs, port A's set is issued. All of port B's memory-side valid flags are low in that clock, and `coll_b_o` is high for that clock only.
- R5: In the clock after a port loses, that port's memory side issues the captured four-slot set (valid, write and address) unchanged.
- R6: A set presented on a port while its ready is low is dropped and never appears on the memory side.
- R7: A port that is replaying wins any collision in that clock. The other port is flagged through its collision output and is stalled in turn.
- R8: A port's ready is low only in the replay clock and is high again in the following clock. Both ports are never stalled at the same time.
- R9: After reset both ready outputs are high, no collision is flagged and no set is held.
- R10: In a clock with no collision, each port's presented set (or its replay) goes to its memory side in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_a_i | input | NCH | Port A slot valid flags |
| cmd_we_a_i | input | NCH | Port A slot write flags (1 = write) |
| cmd_addr_a_i | input | NCH*AW | Port A slot addresses; slot n at [n*AW +: AW] |
| rdy_a_o | output | 1 | Port A may present a set |
| coll_a_o | output | 1 | Port A lost a collision this clock |
| cmd_valid_b_i | input | NCH | Port B slot valid flags |
| cmd_we_b_i | input | NCH | Port B slot write flags |
| cmd_addr_b_i | input | NCH*AW | Port B slot addresses |
| rdy_b_o | output | 1 | Port B may present a set |
| coll_b_o | output | 1 | Port B lost a collision this clock |
| mem_valid_a_o | output | NCH | Issued port A slot valid flags |
| mem_we_a_o | output | NCH | Issued port A write flags |
| mem_addr_a_o | output | NCH*AW | Issued port A addresses |
| mem_valid_b_o | output | NCH | Issued port B slot valid flags |
| mem_we_b_o | output | NCH | Issued port B write flags |
| mem_addr_b_o | output | NCH*AW | Issued port B addresses |

## Verification
The bench aims at addresses that differ only above bit 2, and at those that differ only in bit 2. A design that compares too many or too few bits either stalls traffic that has no conflict or lets a real conflict through. It also offers equal banks on different slots and equal banks paired with an invalid slot. A design that compares across slots or ignores the valid flags would then raise false stalls. Directed runs repeat a conflict on one bank so that the winner must change every clock, and they present a new set during a stall. A design without replay priority would starve port B. One that accepts input while not ready would leak the dropped set to memory. Seeded random traffic on a narrow address range covers the rest against a bench model.

// File: rtl/bca_pkg.sv
package bca_pkg;
  localparam int BANK_W = 3;
  typedef enum logic {WIN_A = 1'b0, WIN_B = 1'b1} win_e;
endpackage

// File: rtl/bca_bank_cmp.sv
module bca_bank_cmp #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic [NCH-1:0]    valid_a_i,
  input  logic [NCH-1:0]    valid_b_i,
  input  logic [NCH*AW-1:0] addr_a_i,
  input  logic [NCH*AW-1:0] addr_b_i,
  output logic [NCH-1:0]    hit_o
);
  import bca_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BANK_W-1:0] bank_a, bank_b;
    assign bank_a   = addr_a_i[c*AW +: BANK_W];
    assign bank_b   = addr_b_i[c*AW +: BANK_W];
    assign hit_o[c] = valid_a_i[c] & valid_b_i[c] & (bank_a == bank_b);
  end
endmodule

// File: rtl/bca_port_hold.sv
module bca_port_hold #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    in_valid_i,
  input  logic [NCH-1:0]    in_we_i,
  input  logic [NCH*AW-1:0] in_addr_i,
  input  logic              capture_i,
  output logic              held_o,
  output logic [NCH-1:0]    eff_valid_o,
  output logic [NCH-1:0]    eff_we_o,
  output logic [NCH*AW-1:0] eff_addr_o
);
  logic              held_q;
  logic [NCH-1:0]    valid_q, we_q;
  logic [NCH*AW-1:0] addr_q;

  // held set replaces the live input; live input is dropped meanwhile
  assign held_o      = held_q;
  assign eff_valid_o = held_q ? valid_q : in_valid_i;
  assign eff_we_o    = held_q ? we_q    : in_we_i;
  assign eff_addr_o  = held_q ? addr_q  : in_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      valid_q <= '0;
      we_q    <= '0;
      addr_q  <= '0;
    end else begin
      held_q <= capture_i;
      if (capture_i) begin
        valid_q <= eff_valid_o;
        we_q    <= eff_we_o;
        addr_q  <= eff_addr_o;
      end
    end
  end
endmodule

// File: rtl/bank_coll_arb.sv
module bank_coll_arb #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    cmd_valid_a_i,
  input  logic [NCH-1:0]    cmd_we_a_i,
  input  logic [NCH*AW-1:0] cmd_addr_a_i,
  output logic              rdy_a_o,
  output logic              coll_a_o,
  input  logic [NCH-1:0]    cmd_valid_b_i,
  input  logic [NCH-1:0]    cmd_we_b_i,
  input  logic [NCH*AW-1:0] cmd_addr_b_i,
  output logic              rdy_b_o,
  output logic              coll_b_o,
  output logic [NCH-1:0]    mem_valid_a_o,
  output logic [NCH-1:0]    mem_we_a_o,
  output logic [NCH*AW-1:0] mem_addr_a_o,
  output logic [NCH-1:0]    mem_valid_b_o,
  output logic [NCH-1:0]    mem_we_b_o,
  output logic [NCH*AW-1:0] mem_addr_b_o
);
  import bca_pkg::*;

  logic              held_a, held_b;
  logic [NCH-1:0]    ev_a, ev_b, ew_a, ew_b, hit;
  logic [NCH*AW-1:0] ea_a, ea_b;
  logic              any_hit;
  win_e              winner;

  bca_port_hold #(.NCH(NCH), .AW(AW)) u_hold_a (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(cmd_valid_a_i), .in_we_i(cmd_we_a_i), .in_addr_i(cmd_addr_a_i),
    .capture_i(coll_a_o), .held_o(held_a),
    .eff_valid_o(ev_a), .eff_we_o(ew_a), .eff_addr_o(ea_a)
  );

  bca_port_hold #(.NCH(NCH), .AW(AW)) u_hold_b (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(cmd_valid_b_i), .in_we_i(cmd_we_b_i), .in_addr_i(cmd_addr_b_i),
    .capture_i(coll_b_o), .held_o(held_b),
    .eff_valid_o(ev_b), .eff_we_o(ew_b), .eff_addr_o(ea_b)
  );

  bca_bank_cmp #(.NCH(NCH), .AW(AW)) u_cmp (
    .valid_a_i(ev_a), .valid_b_i(ev_b),
    .addr_a_i(ea_a), .addr_b_i(ea_b),
    .hit_o(hit)
  );

  // a replaying port wins; otherwise A wins
  always_comb begin
    winner = WIN_A;
    if (held_b && !held_a) winner = WIN_B;
  end

  assign any_hit  = |hit;
  assign coll_a_o = any_hit & (winner == WIN_B);
  assign coll_b_o = any_hit & (winner == WIN_A);
  assign rdy_a_o  = ~held_a;
  assign rdy_b_o  = ~held_b;

  assign mem_valid_a_o = ev_a & {NCH{~coll_a_o}};
  assign mem_valid_b_o = ev_b & {NCH{~coll_b_o}};
  assign mem_we_a_o    = ew_a;
  assign mem_we_b_o    = ew_b;
  assign mem_addr_a_o  = ea_a;
  assign mem_addr_b_o  = ea_b;

  // R4
  b_loses_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_b_o |-> (mem_valid_b_o == '0));
  // R5
  stall_follows_coll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_a_o || coll_b_o) |=> (!rdy_a_o || !rdy_b_o));
  // R5
  replay_same_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_b_o |=> (mem_addr_b_o == $past(cmd_addr_b_i)));
  // R7
  replay_never_loses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_a_o |-> !coll_a_o);
  // R8
  rdy_b_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_b_o |=> rdy_b_o);
  // R8
  one_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(held_a && held_b));
endmodule

// File: tb/tb_bank_coll_arb.sv
module tb_bank_coll_arb;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int VW  = NCH*AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NCH-1:0] va, wa, vb, wb;
  logic [VW-1:0]  aa, ab;
  logic rdy_a, rdy_b, coll_a, coll_b;
  logic [NCH-1:0] mva, mwa, mvb, mwb;
  logic [VW-1:0]  maa, mab;

  int total = 0, bad = 0;
  bit done = 0;

  bank_coll_arb #(.NCH(NCH), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_a_i(va), .cmd_we_a_i(wa), .cmd_addr_a_i(aa),
    .rdy_a_o(rdy_a), .coll_a_o(coll_a),
    .cmd_valid_b_i(vb), .cmd_we_b_i(wb), .cmd_addr_b_i(ab),
    .rdy_b_o(rdy_b), .coll_b_o(coll_b),
    .mem_valid_a_o(mva), .mem_we_a_o(mwa), .mem_addr_a_o(maa),
    .mem_valid_b_o(mvb), .mem_we_b_o(mwb), .mem_addr_b_o(mab)
  );

  always #2 clk = ~clk;

  // model state
  bit mh_a = 0, mh_b = 0;
  logic [NCH-1:0] sv_a = '0, sw_a = '0, sv_b = '0, sw_b = '0;
  logic [VW-1:0]  sa_a = '0, sa_b = '0;

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit slot_hit(input logic [NCH-1:0] v1, input logic [NCH-1:0] v2,
                                  input logic [VW-1:0] a1, input logic [VW-1:0] a2);
    bit h = 0;
    for (int c = 0; c < NCH; c++)
      if (v1[c] && v2[c] && a1[c*AW +: 3] == a2[c*AW +: 3]) h = 1;
    return h;
  endfunction

  function automatic logic [VW-1:0] pk(input logic [AW-1:0] x0, input logic [AW-1:0] x1,
                                       input logic [AW-1:0] x2, input logic [AW-1:0] x3);
    return {x3, x2, x1, x0};
  endfunction

  task automatic cyc(input logic [NCH-1:0] iva, input logic [NCH-1:0] iwa, input logic [VW-1:0] iaa,
                     input logic [NCH-1:0] ivb, input logic [NCH-1:0] iwb, input logic [VW-1:0] iab);
    logic [NCH-1:0] ev_a, ev_b, ew_a, ew_b;
    logic [VW-1:0] ea_a, ea_b;
    bit h, ca, cb;
    @(negedge clk);
    va = iva; wa = iwa; aa = iaa; vb = ivb; wb = iwb; ab = iab;
    #1;
    ev_a = mh_a ? sv_a : iva; ew_a = mh_a ? sw_a : iwa; ea_a = mh_a ? sa_a : iaa;
    ev_b = mh_b ? sv_b : ivb; ew_b = mh_b ? sw_b : iwb; ea_b = mh_b ? sa_b : iab;
    h  = slot_hit(ev_a, ev_b, ea_a, ea_b);
    ca = h && mh_b && !mh_a;
    cb = h && !ca;
    chk("R8 rdy_a", VW'(rdy_a), VW'(!mh_a));
    chk("R8 rdy_b", VW'(rdy_b), VW'(!mh_b));
    chk("R7 coll_a", VW'(coll_a), VW'(ca));
    chk("R4 coll_b", VW'(coll_b), VW'(cb));
    chk("R10 mem_valid_a", VW'(mva), VW'(ca ? '0 : ev_a));
    chk("R10 mem_valid_b", VW'(mvb), VW'(cb ? '0 : ev_b));
    if (!ca) begin chk("R5 we_a", VW'(mwa), VW'(ew_a)); chk("R5 addr_a", maa, ea_a); end
    if (!cb) begin chk("R5 we_b", VW'(mwb), VW'(ew_b)); chk("R5 addr_b", mab, ea_b); end
    @(posedge clk);
    mh_a = ca; mh_b = cb;
    if (ca) begin sv_a = ev_a; sw_a = ew_a; sa_a = ea_a; end
    if (cb) begin sv_b = ev_b; sw_b = ew_b; sa_b = ea_b; end
  endtask

  task automatic idle();
    cyc('0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    va = '0; wa = '0; aa = '0; vb = '0; wb = '0; ab = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R9 reset state
    #1;
    chk("R9 rdy", VW'({rdy_a, rdy_b}), VW'(2'b11));
    chk("R9 coll", VW'({coll_a, coll_b}), VW'(2'b00));
    chk("R9 mem_valid", VW'({mva, mvb}), VW'(0));
    // R10 different banks pass
    cyc(4'h1, 4'h1, pk(16'h0001, 0, 0, 0), 4'h1, 4'h0, pk(16'h0002, 0, 0, 0));
    // R1 upper bits differ, bank equal -> B stalls
    cyc(4'h1, 4'h0, pk(16'h0015, 0, 0, 0), 4'hF, 4'h5, pk(16'h0005, 16'h0100, 16'h0200, 16'h0300));
    // R6 new B set while not ready is dropped; replay shows instead
    cyc(4'h0, 4'h0, '0, 4'hF, 4'hF, pk(16'h7777, 16'h7777, 16'h7777, 16'h7777));
    chk("R6 replay addr", mab, pk(16'h0005, 16'h0100, 16'h0200, 16'h0300));
    idle();
    chk("R6 dropped set absent", VW'(mvb), VW'(0));
    // R1 differ only in bit 2 -> no collision
    cyc(4'h1, 4'h0, pk(16'h0001, 0, 0, 0), 4'h1, 4'h0, pk(16'h0005, 0, 0, 0));
    // R2 same bank, different slots
    cyc(4'h1, 4'h0, pk(16'h0003, 0, 0, 0), 4'h2, 4'h0, pk(0, 16'h0003, 0, 0));
    chk("R2 no cross-slot coll", VW'(coll_b), VW'(0));
    // R3 invalid slot ignored
    cyc(4'h4, 4'h0, pk(0, 0, 16'h0006, 0), 4'h0, 4'h0, pk(0, 0, 16'h0006, 0));
    chk("R3 invalid no coll", VW'(coll_b), VW'(0));
    // R7 back-to-back on one bank alternates winner
    cyc(4'h2, 4'h0, pk(0, 16'h0004, 0, 0), 4'h2, 4'h2, pk(0, 16'h0014, 0, 0));
    cyc(4'h2, 4'h2, pk(0, 16'h0024, 0, 0), 4'h0, 4'h0, '0);
    chk("R7 A flagged vs replay", VW'(coll_a), VW'(1));
    cyc(4'h0, 4'h0, '0, 4'h2, 4'h0, pk(0, 16'h0034, 0, 0));
    chk("R7 B flagged vs A replay", VW'(coll_b), VW'(1));
    idle(); idle();
    // seeded random traffic on a narrow bank range
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic [VW-1:0] ra, rb;
      for (int c = 0; c < NCH; c++) begin
        ra[c*AW +: AW] = AW'($urandom() & 32'h3F);
        rb[c*AW +: AW] = AW'($urandom() & 32'h3F);
      end
      cyc(NCH'($urandom()), NCH'($urandom()), ra, NCH'($urandom()), NCH'($urandom()), rb);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule